// File: doc/BRIEF.md
# Serial ADC Output Lane Serializer

This block turns a stream of parallel 12-bit conversion codes into a single serial data lane, of the kind a converter sends to a capture device. It runs from one clock at twice the bit rate. Each serial bit occupies two clock cycles. Next to the data it drives a bit clock and a word marker, so a receiver can recover both the bits and the word boundaries. A second lane exists on the port list but is held disabled, because the block only works in single-lane operation.

A mode input selects the word length. In narrow mode each word carries the twelve code bits and nothing else. In wide mode two trailing filler bits follow the code, which keeps the framing compatible with a receiver built for 14-bit words. The filler bits are 0 unless the overrange flag that came in with that sample was set; in that case both filler bits are 1. Each code is taken in at a word boundary. It passes through a fixed pipeline that is a whole number of words deep before it reaches the lane, which models the conversion latency of a real converter.

Top module: `adc_lane_serializer`

## Requirements
- R1: Each code is sent most significant bit first: bit 11 goes out in the first bit slot of the word and bit 0 in the twelfth.
- R2: When `wide_mode_i` is 0 at a word's start, the word lasts 12 bit slots and the next word's bit 11 follows bit 0 at once. When it is 1, the word lasts 14 slots and the slots after bit 0 carry two filler bits.
- R3: Both filler bits of a wide word are 0 when the overrange flag captured with that sample was 0.
- R4: Both filler bits of a wide word are 1 when the overrange flag captured with that sample was 1.
- R5: The code and overrange flag present on the inputs at the clock edge that starts word k are sent in word k+LATENCY (default 6).
- R6: `frame_o` is 1 during the first 6 bit slots of a narrow word and the first 7 slots of a wide word, and 0 for the remaining slots. It rises in the slot that carries bit 11.
- R7: Each bit slot is two clock cycles long. `dco_o` is 0 in the first cycle and 1 in the second, and `lane_a_o` and `frame_o` hold the same value in both cycles of a slot.
- R8: `wide_mode_i` is sampled only at the edge that starts a word; changing it in the middle of a word does not change that word's length or frame pattern.
- R9: `lane_b_o` and `lane_b_oe_o` are 0 at all times.
- R10: While `rst` is high, `lane_a_o`, `frame_o`, `dco_o`, `lane_b_o` and `lane_b_oe_o` are all 0. The first word starts at the second clock edge after reset is released, and the first LATENCY words after reset carry all-zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the serial bit rate |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 12 | Parallel conversion code, captured at each word start |
| ovr_i | input | 1 | Overrange flag, captured together with the code |
| wide_mode_i | input | 1 | 0 selects 12-slot words, 1 selects 14-slot words |
| lane_a_o | output | 1 | Serial data lane |
| lane_b_o | output | 1 | Second lane data, held idle at 0 |
| lane_b_oe_o | output | 1 | Second lane enable, held at 0 |
| frame_o | output | 1 | Word marker, high for the first half of each word |
| dco_o | output | 1 | Bit clock; its rising edge falls in the middle of each bit slot |

## Verification
The embedded assertions check, on every cycle, the properties that depend on the cycle just before: the bit clock toggles every cycle, the lane changes only when a bit slot ends, the frame rises only on the first slot of a word, the bit counter stays within the current word length, the latched mode changes only at a word boundary, and the filler bits are cleared when the overrange flag is 0. Some properties need a record kept across many words, and only the bench scenarios can show them. These are the six-word latency from capture to lane, the exact bit order and full word contents, the overrange filler values, the exact count of frame-high slots in each mode, the zero-filled pipeline after reset, and the fact that a mode glitch in mid-word has no effect.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

  // width of one conversion code
  localparam int unsigned CODE_W = 12;

  // one pipeline entry: the code and the overrange flag that came with it
  typedef struct packed {
    logic              ovr;
    logic [CODE_W-1:0] code;
  } sample_t;

  localparam int unsigned SAMPLE_W = $bits(sample_t);

endpackage

// File: rtl/adcser_bit_timer.sv
module adcser_bit_timer #(
  parameter int unsigned NARROW_W = 12,
  parameter int unsigned WIDE_W   = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic wide_mode_i,
  output logic step_o,
  output logic wrap_o,
  output logic frame_o,
  output logic dco_o
);
  localparam int unsigned CNT_W = $clog2(WIDE_W);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW_W - 1);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE_W - 1);
  localparam logic [CNT_W-1:0] NARROW_HALF = CNT_W'((NARROW_W + 1) / 2);
  localparam logic [CNT_W-1:0] WIDE_HALF   = CNT_W'((WIDE_W + 1) / 2);

  logic             phase_q;
  logic             mode_q;
  logic             frame_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] half_idx;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;

  assign last_idx = mode_q ? WIDE_LAST : NARROW_LAST;
  assign half_idx = mode_q ? WIDE_HALF : NARROW_HALF;
  assign cnt_nxt  = bit_cnt + 1'b1;
  assign wrap     = phase_q && (bit_cnt == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      mode_q  <= wide_mode_i;
      frame_q <= 1'b0;
      bit_cnt <= wide_mode_i ? WIDE_LAST : NARROW_LAST;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (wrap) begin
          bit_cnt <= '0;
          mode_q  <= wide_mode_i;
          frame_q <= 1'b1;
        end else begin
          bit_cnt <= cnt_nxt;
          frame_q <= (cnt_nxt < half_idx);
        end
      end
    end
  end

  assign step_o  = phase_q;
  assign wrap_o  = wrap;
  assign frame_o = frame_q;
  assign dco_o   = phase_q;

  // R7
  dco_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dco_o != $past(dco_o)));

  // R6
  frame_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_o) |-> (bit_cnt == '0));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= last_idx);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(mode_q)) |-> $past(wrap));

endmodule

// File: rtl/adcser_sample_delay.sv
module adcser_sample_delay #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else if (adv_i) stage[0] <= in_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[g] <= '0;
      else if (adv_i) stage[g] <= stage[g-1];
    end
  end

  assign out_o = stage[DEPTH-1];

endmodule

// File: rtl/adcser_lane_shifter.sv
module adcser_lane_shifter
  import adcser_pkg::*;
#(
  parameter int unsigned PAD_W = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    step_i,
  input  logic    load_i,
  input  sample_t word_i,
  output logic    lane_o
);
  localparam int unsigned SR_W = CODE_W + PAD_W;

  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= {word_i.code, {PAD_W{word_i.ovr}}};
    end else if (step_i) begin
      sr_q <= {sr_q[SR_W-2:0], 1'b0};
    end
  end

  assign lane_o = sr_q[SR_W-1];

  // R3
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !word_i.ovr) |=> (sr_q[PAD_W-1:0] == '0));

  // R7
  lane_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(lane_o)) |-> $past(step_i));

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
  import adcser_pkg::*;
#(
  parameter int unsigned PAD_W   = 2,
  parameter int unsigned LATENCY = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ovr_i,
  input  logic              wide_mode_i,
  output logic              lane_a_o,
  output logic              lane_b_o,
  output logic              lane_b_oe_o,
  output logic              frame_o,
  output logic              dco_o
);
  localparam int unsigned WIDE_W = CODE_W + PAD_W;

  logic    step;
  logic    wrap;
  sample_t cap_word;
  sample_t out_word;
  logic    lane_b_q;
  logic    lane_b_oe_q;

  assign cap_word = '{ovr: ovr_i, code: code_i};

  adcser_bit_timer #(
    .NARROW_W (CODE_W),
    .WIDE_W   (WIDE_W)
  ) i_timer (
    .clk         (clk),
    .rst         (rst),
    .wide_mode_i (wide_mode_i),
    .step_o      (step),
    .wrap_o      (wrap),
    .frame_o     (frame_o),
    .dco_o       (dco_o)
  );

  adcser_sample_delay #(
    .DEPTH (LATENCY),
    .W     (SAMPLE_W)
  ) i_delay (
    .clk   (clk),
    .rst   (rst),
    .adv_i (wrap),
    .in_i  (cap_word),
    .out_o (out_word)
  );

  adcser_lane_shifter #(
    .PAD_W (PAD_W)
  ) i_shift (
    .clk    (clk),
    .rst    (rst),
    .step_i (step),
    .load_i (wrap),
    .word_i (out_word),
    .lane_o (lane_a_o)
  );

  // second lane is parked: data and enable are registered idle zeros
  always_ff @(posedge clk) begin
    lane_b_q    <= 1'b0;
    lane_b_oe_q <= 1'b0;
  end

  assign lane_b_o    = lane_b_q;
  assign lane_b_oe_o = lane_b_oe_q;

endmodule

// File: tb/test_adc_lane_serializer.sv
module test_adc_lane_serializer;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] code_i = '0;
  logic        ovr_i = 1'b0;
  logic        wide_mode_i = 1'b0;
  logic        lane_a_o, lane_b_o, lane_b_oe_o, frame_o, dco_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] slot_code [0:255];
  logic        slot_ovr  [0:255];
  logic        slot_mode [0:255];
  int          wn;

  always #10 clk = ~clk;

  adc_lane_serializer i_adc_lane_serializer (
    .clk         (clk),
    .rst         (rst),
    .code_i      (code_i),
    .ovr_i       (ovr_i),
    .wide_mode_i (wide_mode_i),
    .lane_a_o    (lane_a_o),
    .lane_b_o    (lane_b_o),
    .lane_b_oe_o (lane_b_oe_o),
    .frame_o     (frame_o),
    .dco_o       (dco_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // reset, then release with the first slot's inputs; ends at the start of word 0
  task automatic begin_stream(input bit mode, input logic [11:0] c0, input bit o0);
    @(negedge clk);
    rst = 1'b1;
    code_i = c0; ovr_i = o0; wide_mode_i = mode;
    @(negedge clk);
    @(negedge clk);
    chk({lane_a_o, frame_o, dco_o, lane_b_o, lane_b_oe_o} == 5'b0, "R10",
        "outputs in reset", {lane_a_o, frame_o, dco_o, lane_b_o, lane_b_oe_o}, 0);
    wn = 0;
    slot_code[0] = c0; slot_ovr[0] = o0; slot_mode[0] = mode;
    rst = 1'b0;
    @(negedge clk);
    chk(dco_o == 1'b1 && frame_o == 1'b0, "R10", "first cycle after release",
        {dco_o, frame_o}, 2'b10);
    @(negedge clk);
  endtask

  // one word: drive the next slot, collect and check the current word
  task automatic run_word(input logic [11:0] nc, input bit no, input bit nm,
                          input bit glitch, input string dreq);
    int          len;
    int          half;
    logic [13:0] got;
    logic [13:0] exp;
    logic [11:0] ec;
    bit          eo;
    bit          frame_ok;
    bit          slot_ok;
    bit          b_ok;
    len  = slot_mode[wn] ? 14 : 12;
    half = (len + 1) / 2;
    if (wn >= LAT) begin
      ec = slot_code[wn-LAT]; eo = slot_ovr[wn-LAT];
    end else begin
      ec = '0; eo = 1'b0;
    end
    exp = {ec, eo, eo};
    got = '0;
    frame_ok = 1'b1; slot_ok = 1'b1; b_ok = 1'b1;
    code_i = nc; ovr_i = no; wide_mode_i = nm;
    slot_code[wn+1] = nc; slot_ovr[wn+1] = no; slot_mode[wn+1] = nm;
    for (int b = 0; b < len; b++) begin
      logic v0;
      logic f0;
      if (b > 0) @(negedge clk);
      if (glitch && b == 2) wide_mode_i = ~nm;
      if (glitch && b == 5) wide_mode_i = nm;
      v0 = lane_a_o; f0 = frame_o;
      if (dco_o != 1'b0) slot_ok = 1'b0;
      @(negedge clk);
      if (dco_o != 1'b1 || lane_a_o != v0 || frame_o != f0) slot_ok = 1'b0;
      if (frame_o != (b < half)) frame_ok = 1'b0;
      if (lane_b_o || lane_b_oe_o) b_ok = 1'b0;
      got = {got[12:0], lane_a_o};
    end
    if (len == 14) begin
      chk(got[13:2] == exp[13:2], dreq, $sformatf("word %0d code (wide)", wn),
          got[13:2], exp[13:2]);
      chk(got[1:0] == exp[1:0], eo ? "R4" : "R3", $sformatf("word %0d filler", wn),
          got[1:0], exp[1:0]);
    end else begin
      chk(got[11:0] == exp[13:2], dreq, $sformatf("word %0d code (narrow)", wn),
          got[11:0], exp[13:2]);
    end
    chk(frame_ok, glitch ? "R8" : "R6", $sformatf("word %0d frame pattern len %0d", wn, len),
        frame_ok, 1);
    chk(slot_ok, "R7", $sformatf("word %0d slot timing", wn), slot_ok, 1);
    chk(b_ok, "R9", $sformatf("word %0d lane B idle", wn), b_ok, 1);
    @(negedge clk);
    chk(frame_o == 1'b1 && dco_o == 1'b0, "R2", $sformatf("word %0d boundary after %0d slots", wn, len),
        {frame_o, dco_o}, 2'b10);
    wn++;
  endtask

  // R10: pipeline carries zeros after reset
  task automatic t_reset_fill();
    begin_stream(1'b0, 12'hFFF, 1'b1);
    for (int i = 0; i < LAT; i++) run_word(12'hFFF, 1'b1, 1'b0, 1'b0, "R10");
  endtask

  // R1, R5: distinct codes in narrow mode, including a lone marker
  task automatic t_narrow_latency();
    begin_stream(1'b0, 12'h800, 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [11:0] c;
      c = (i == 3) ? 12'h001 : 12'(12'hA5C ^ (i * 12'h137));
      run_word(c, 1'b0, 1'b0, 1'b0, (i < LAT) ? "R10" : "R5");
    end
    for (int i = 0; i < LAT; i++) run_word(12'h000, 1'b0, 1'b0, 1'b0, "R1");
  endtask

  // R2, R3: wide mode with clear overrange
  task automatic t_wide_pads();
    begin_stream(1'b1, 12'hC3A, 1'b0);
    for (int i = 0; i < 14; i++)
      run_word(12'(12'h5A5 + i * 12'h0F1), 1'b0, 1'b1, 1'b0, (i < LAT) ? "R10" : "R1");
  endtask

  // R4: overrange flag follows its own sample through the pipeline
  task automatic t_overrange();
    begin_stream(1'b1, 12'hFFF, 1'b1);
    for (int i = 0; i < 14; i++)
      run_word(12'(i * 12'h111), i[0], 1'b1, 1'b0, "R5");
  endtask

  // R8: mode changes per word, with a mid-word glitch on the mode input
  task automatic t_mode_switch();
    begin_stream(1'b0, 12'h3C3, 1'b1);
    for (int i = 0; i < 14; i++)
      run_word(12'(12'hE01 - i * 12'h055), i[1], i[0], 1'b1, "R8");
  endtask

  initial begin
    t_reset_fill();
    t_narrow_latency();
    t_wide_pads();
    t_overrange();
    t_mode_switch();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule